// File: doc/BRIEF.md
# Inactivity Auto-Sleep Controller

This block decides when a sampling sensor core should drop from its normal (wake) output data rate to a slower sleep rate. It measures how long no qualifying activity has been seen. The length of that quiet period is programmed in fixed real-time units, so the controller converts each unit into a number of sample ticks that depends on the wake rate in use. When the programmed period runs out, the block enters sleep mode. It returns to wake mode as soon as an activity source that is allowed to wake it fires.

There are four activity sources, one strobe bit each. A keep-awake mask selects which sources restart the quiet-period count while awake. A separate wake mask selects which sources end sleep mode. The detection functions keep running in sleep mode at the slower rate that `rate_sel` reports. A latched interrupt marks every mode change. System software clears it with a strobe.

Rate codes are 0..7, meaning 800, 400, 200, 100, 50, 12.5, 6.25 and 1.56 Hz.

Top module: `inact_sleep_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `sleep_mode`, `mode_irq` and `rate_sel` become 0.
- R2: `rate_sel` is a register. After each edge it holds the `sleep_rate` value sampled at that edge if the block is now asleep, and the `wake_rate` value sampled at that edge if the block is now awake.
- R3: With `auto_sleep_en` = 1, limit N and no restart, sleep is entered on the edge of the (N*T+1)-th `sample_tick`. T is 256, 128, 64, 32, 16, 4, 2 or 1 for `wake_rate` codes 0 through 7. No sleep entry happens on an edge without `sample_tick`.
- R4: A limit of 0 enters sleep on the first idle `sample_tick`.
- R5: While awake, a cycle where any bit of `act_evt & keep_mask` is 1 clears the elapsed count. Sources outside `keep_mask` do not affect the count.
- R6: With `auto_sleep_en` = 0, the block is in wake mode after the next edge and stays there. The count is held at zero.
- R7: While asleep, a cycle where any bit of `act_evt & wake_mask` is 1 returns the block to wake mode at that edge. Other sources leave it asleep.
- R8: When `mode_irq_en` is 1, every change of `sleep_mode` (in either direction) sets `mode_irq` at the same edge. When `mode_irq_en` is 0, no change sets it.
- R9: `mode_irq` stays 1 until an edge with `irq_clr` = 1 and no new setting event. A set at the same edge as a clear wins.
- R10: Entering wake mode starts the count from zero, so the next sleep again needs the full N*T+1 idle ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle strobe per output sample |
| wake_rate | input | 3 | Rate code used in wake mode |
| sleep_rate | input | 3 | Rate code used in sleep mode |
| auto_sleep_en | input | 1 | Allows automatic sleep entry |
| idle_limit | input | 8 | Quiet period in steps of 320 ms (640 ms at code 7) |
| mode_irq_en | input | 1 | Enables the mode-change interrupt |
| irq_clr | input | 1 | Clears the latched interrupt |
| act_evt | input | 4 | Activity strobes, one bit per source |
| keep_mask | input | 4 | Sources that restart the quiet count |
| wake_mask | input | 4 | Sources that end sleep mode |
| sleep_mode | output | 1 | 1 while in sleep mode |
| rate_sel | output | 3 | Rate code currently in force |
| mode_irq | output | 1 | Latched mode-change interrupt |

## Verification
The properties take two things for granted about the inputs.
- `sample_tick` is a single-cycle strobe.
- `wake_rate` does not move while a quiet period is being counted. A change in the middle of a count would mix step lengths, which neither the RTL nor the bench model gives meaning to.

The random stimulus respects both assumptions. It changes the rate codes, masks and limit only at the start of a segment, where `auto_sleep_en` is dropped for one cycle to force the count back to zero. Activity strobes and clears are sparse, so quiet periods long enough to reach sleep actually occur.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic {
    MODE_WAKE  = 1'b0,
    MODE_SLEEP = 1'b1
  } pmode_t;

  // Ticks per quiet-period step: 320 ms at codes 0..6, 640 ms at code 7.
  function automatic int isc_ticks(input int code);
    if (code < 5) return 256 >> code;
    return 4 >> (code - 5);
  endfunction

endpackage

// File: rtl/isc_src_gate.sv
module isc_src_gate #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] keep_mask,
  input  logic [NSRC-1:0] wake_mask,
  output logic            keep_hit,
  output logic            wake_hit
);

  logic [NSRC-1:0] keep_v;
  logic [NSRC-1:0] wake_v;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign keep_v[g] = evt[g] & keep_mask[g];
    assign wake_v[g] = evt[g] & wake_mask[g];
  end

  assign keep_hit = |keep_v;
  assign wake_hit = |wake_v;

endmodule

// File: rtl/isc_idle_timer.sv
module isc_idle_timer #(
  parameter int DUR_W = 8,
  parameter int PRE_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [PRE_W-1:0] tps,
  input  logic [DUR_W-1:0] limit,
  output logic             expire
);

  localparam logic [DUR_W-1:0] STEP_MAX = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   pre_nx;
  logic [DUR_W-1:0] step_q;
  logic             wrap;

  assign pre_nx = {1'b0, pre_q} + 1'b1;
  assign wrap   = pre_nx >= {1'b0, tps};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_q  <= '0;
      step_q <= '0;
    end else if (tick) begin
      if (wrap) begin
        pre_q <= '0;
        if (step_q != STEP_MAX) step_q <= step_q + 1'b1;
      end else begin
        pre_q <= pre_nx[PRE_W-1:0];
      end
    end
  end

  // The check uses the step count before this tick is added.
  assign expire = tick && !restart && (step_q >= limit);

endmodule

// File: rtl/isc_mode_fsm.sv
module isc_mode_fsm
  import isc_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en,
  input  logic              expire,
  input  logic              wake_hit,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic [RATE_W-1:0] wake_rate,
  input  logic [RATE_W-1:0] sleep_rate,
  output pmode_t            mode_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              irq_q
);

  pmode_t mode_d;
  logic   flip;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_WAKE:  if (expire)              mode_d = MODE_SLEEP;
      MODE_SLEEP: if (!auto_en || wake_hit) mode_d = MODE_WAKE;
      default:                              mode_d = MODE_WAKE;
    endcase
  end

  assign flip = (mode_d != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_WAKE;
      rate_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rate_q <= (mode_d == MODE_SLEEP) ? sleep_rate : wake_rate;
      if (flip && irq_en) irq_q <= 1'b1;
      else if (irq_clr)   irq_q <= 1'b0;
    end
  end

endmodule

// File: rtl/inact_sleep_ctrl.sv
module inact_sleep_ctrl
  import isc_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int RATE_W    = 3,
  parameter int DUR_W     = 8,
  parameter int MAX_TICKS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic [RATE_W-1:0] wake_rate,
  input  logic [RATE_W-1:0] sleep_rate,
  input  logic              auto_sleep_en,
  input  logic [DUR_W-1:0]  idle_limit,
  input  logic              mode_irq_en,
  input  logic              irq_clr,
  input  logic [NSRC-1:0]   act_evt,
  input  logic [NSRC-1:0]   keep_mask,
  input  logic [NSRC-1:0]   wake_mask,
  output logic              sleep_mode,
  output logic [RATE_W-1:0] rate_sel,
  output logic              mode_irq
);

  localparam int PRE_W = $clog2(MAX_TICKS + 1);

  logic             keep_hit;
  logic             wake_hit;
  logic             restart;
  logic             expire;
  logic [PRE_W-1:0] tps;
  pmode_t           mode_q;

  assign tps     = PRE_W'(isc_ticks(int'(wake_rate)));
  assign restart = (mode_q == MODE_SLEEP) || !auto_sleep_en || keep_hit;

  isc_src_gate #(.NSRC(NSRC)) gate_i (
    .evt       (act_evt),
    .keep_mask (keep_mask),
    .wake_mask (wake_mask),
    .keep_hit  (keep_hit),
    .wake_hit  (wake_hit)
  );

  isc_idle_timer #(.DUR_W(DUR_W), .PRE_W(PRE_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (sample_tick),
    .tps     (tps),
    .limit   (idle_limit),
    .expire  (expire)
  );

  isc_mode_fsm #(.RATE_W(RATE_W)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .auto_en    (auto_sleep_en),
    .expire     (expire),
    .wake_hit   (wake_hit),
    .irq_en     (mode_irq_en),
    .irq_clr    (irq_clr),
    .wake_rate  (wake_rate),
    .sleep_rate (sleep_rate),
    .mode_q     (mode_q),
    .rate_q     (rate_sel),
    .irq_q      (mode_irq)
  );

  assign sleep_mode = (mode_q == MODE_SLEEP);

endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int NSRC   = 4,
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_tick,
  input logic [RATE_W-1:0] wake_rate,
  input logic [RATE_W-1:0] sleep_rate,
  input logic              auto_sleep_en,
  input logic              mode_irq_en,
  input logic              irq_clr,
  input logic [NSRC-1:0]   act_evt,
  input logic [NSRC-1:0]   keep_mask,
  input logic [NSRC-1:0]   wake_mask,
  input logic              sleep_mode,
  input logic [RATE_W-1:0] rate_sel,
  input logic              mode_irq
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r2_wake_rate: assert property (@(posedge clk) disable iff (rst)
    armed && !sleep_mode |-> rate_sel == $past(wake_rate));

  a_r2_sleep_rate: assert property (@(posedge clk) disable iff (rst)
    armed && sleep_mode |-> rate_sel == $past(sleep_rate));

  a_r3_tick_needed: assert property (@(posedge clk) disable iff (rst)
    !sleep_mode && !sample_tick |=> !sleep_mode);

  a_r5_kick_holds: assert property (@(posedge clk) disable iff (rst)
    !sleep_mode && ((act_evt & keep_mask) != '0) |=> !sleep_mode);

  a_r6_off_wakes: assert property (@(posedge clk) disable iff (rst)
    !auto_sleep_en |=> !sleep_mode);

  a_r7_wake_src: assert property (@(posedge clk) disable iff (rst)
    sleep_mode && ((act_evt & wake_mask) != '0) |=> !sleep_mode);

  a_r7_stay_asleep: assert property (@(posedge clk) disable iff (rst)
    sleep_mode && auto_sleep_en && ((act_evt & wake_mask) == '0) |=> sleep_mode);

  a_r8_irq_on_change: assert property (@(posedge clk) disable iff (rst)
    (sleep_mode != $past(sleep_mode)) && $past(mode_irq_en) |-> mode_irq);

  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_irq) |-> sleep_mode != $past(sleep_mode));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    mode_irq && !irq_clr |=> mode_irq);

endmodule

bind inact_sleep_ctrl isc_checker #(.NSRC(NSRC), .RATE_W(RATE_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .sample_tick   (sample_tick),
  .wake_rate     (wake_rate),
  .sleep_rate    (sleep_rate),
  .auto_sleep_en (auto_sleep_en),
  .mode_irq_en   (mode_irq_en),
  .irq_clr       (irq_clr),
  .act_evt       (act_evt),
  .keep_mask     (keep_mask),
  .wake_mask     (wake_mask),
  .sleep_mode    (sleep_mode),
  .rate_sel      (rate_sel),
  .mode_irq      (mode_irq)
);

// File: tb/inact_sleep_ctrl_tb_top.sv
module inact_sleep_ctrl_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic       tick;
  logic [2:0] wr;
  logic [2:0] sr;
  logic       en;
  logic [7:0] lim;
  logic       ie;
  logic       clr;
  logic [3:0] ev;
  logic [3:0] km;
  logic [3:0] wm;
  logic       sm;
  logic [2:0] rs;
  logic       irq;

  inact_sleep_ctrl dut_i (
    .clk           (clk),
    .rst           (rst),
    .sample_tick   (tick),
    .wake_rate     (wr),
    .sleep_rate    (sr),
    .auto_sleep_en (en),
    .idle_limit    (lim),
    .mode_irq_en   (ie),
    .irq_clr       (clr),
    .act_evt       (ev),
    .keep_mask     (km),
    .wake_mask     (wm),
    .sleep_mode    (sm),
    .rate_sel      (rs),
    .mode_irq      (irq)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // Reference model state
  logic       m_sleep;
  logic       m_irq;
  logic [2:0] m_rate;
  int         m_idle;

  function automatic int tps_of(input logic [2:0] c);
    if (c < 3'd5) return 256 >> c;
    if (c == 3'd5) return 4;
    if (c == 3'd6) return 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic nxt;
    if (rst) begin
      m_sleep = 1'b0; m_irq = 1'b0; m_rate = 3'd0; m_idle = 0;
    end else begin
      nxt = m_sleep;
      if (m_sleep) begin
        if (!en || |(ev & wm)) nxt = 1'b0;
        m_idle = 0;
      end else if (!en || |(ev & km)) begin
        m_idle = 0;
      end else if (tick) begin
        if (m_idle >= int'(lim) * tps_of(wr)) begin
          nxt = 1'b1; m_idle = 0;
        end else begin
          m_idle++;
        end
      end
      if (nxt != m_sleep && ie) m_irq = 1'b1;
      else if (clr)             m_irq = 1'b0;
      m_rate  = nxt ? sr : wr;
      m_sleep = nxt;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R3 model mode", 32'(sm), 32'(m_sleep));
    chk("R2 model rate", 32'(rs), 32'(m_rate));
    chk("R8 model irq", 32'(irq), 32'(m_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; tick = 1'b0; wr = 3'd0; sr = 3'd0; en = 1'b0; lim = 8'd0;
    ie = 1'b0; clr = 1'b0; ev = 4'd0; km = 4'd0; wm = 4'd0;
    @(negedge clk);
    repeat (3) cyc();
    chk("R1 reset sleep_mode", 32'(sm), 0);
    chk("R1 reset mode_irq", 32'(irq), 0);
    chk("R1 reset rate_sel", 32'(rs), 0);
    rst = 1'b0;

    // R3: limit 2 at code 3 (T=32) -> sleep on tick 65
    en = 1'b1; lim = 8'd2; wr = 3'd3; sr = 3'd6; ie = 1'b1; tick = 1'b1;
    repeat (64) cyc();
    chk("R3 awake before limit", 32'(sm), 0);
    cyc();
    chk("R3 asleep at tick N*T+1", 32'(sm), 1);
    chk("R2 sleep rate shown", 32'(rs), 6);
    chk("R8 irq on sleep entry", 32'(irq), 1);

    // R9 clear
    clr = 1'b1; cyc(); clr = 1'b0;
    chk("R9 cleared by strobe", 32'(irq), 0);

    // R7 only wake-mask sources end sleep
    tick = 1'b0; wm = 4'b0100; ev = 4'b0001; cyc(); ev = 4'd0;
    chk("R7 unselected source ignored", 32'(sm), 1);
    ev = 4'b0100; cyc(); ev = 4'd0;
    chk("R7 wake source ends sleep", 32'(sm), 0);
    chk("R2 wake rate shown", 32'(rs), 3);
    chk("R8 irq on wake entry", 32'(irq), 1);

    // R10 restart on wake entry, R9 set beats clear
    lim = 8'd1; wr = 3'd6; tick = 1'b1; clr = 1'b1;
    repeat (2) cyc();
    chk("R10 full period needed after wake", 32'(sm), 0);
    chk("R9 clear while awake", 32'(irq), 0);
    cyc(); clr = 1'b0;
    chk("R10 sleep after N*T+1 ticks", 32'(sm), 1);
    chk("R9 set wins over clear", 32'(irq), 1);

    // R5 keep-awake restart
    tick = 1'b0; ev = 4'b0100; cyc(); ev = 4'd0;
    km = 4'b0010; tick = 1'b1;
    repeat (2) cyc();
    ev = 4'b0010; cyc();
    chk("R5 kick keeps wake", 32'(sm), 0);
    ev = 4'b1000;
    repeat (2) cyc();
    chk("R5 count restarted by kick", 32'(sm), 0);
    cyc(); ev = 4'd0;
    chk("R5 unmasked source ignored", 32'(sm), 1);

    // R6 disable
    en = 1'b0; cyc();
    chk("R6 disable returns to wake", 32'(sm), 0);
    repeat (20) cyc();
    chk("R6 never sleeps while disabled", 32'(sm), 0);

    // R4 zero limit
    en = 1'b1; lim = 8'd0; wr = 3'd0; tick = 1'b0; cyc();
    chk("R4 no sleep without tick", 32'(sm), 0);
    tick = 1'b1; cyc();
    chk("R4 zero limit sleeps on first tick", 32'(sm), 1);

    // R8 interrupt disabled
    ie = 1'b0; clr = 1'b1; tick = 1'b0; cyc(); clr = 1'b0;
    ev = 4'b0100; cyc(); ev = 4'd0;
    chk("R8 no irq when disabled", 32'(irq), 0);
    chk("R7 woke with irq disabled", 32'(sm), 0);

    // R3 largest limit at code 7 (T=1)
    ie = 1'b1; lim = 8'd255; wr = 3'd7; tick = 1'b1;
    repeat (255) cyc();
    chk("R3 limit 255 still awake", 32'(sm), 0);
    cyc();
    chk("R3 limit 255 sleeps on tick 256", 32'(sm), 1);

    // Random segments
    for (int s = 0; s < 60; s++) begin
      en = 1'b0; tick = 1'b0; ev = 4'd0;
      wr  = 3'($urandom % 8);
      sr  = 3'($urandom % 8);
      lim = 8'($urandom % 4);
      km  = 4'($urandom);
      wm  = 4'($urandom);
      ie  = 1'($urandom);
      cyc();
      en = 1'b1;
      for (int c = 0; c < 500; c++) begin
        tick = ($urandom % 3) == 0;
        ev   = (($urandom % 40) == 0) ? 4'($urandom) : 4'd0;
        clr  = ($urandom % 16) == 0;
        cyc();
      end
      clr = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule